// File: doc/BRIEF.md
# Per-Wire Bus Switching Energy Monitor

The monitor watches a parallel bus one sample at a time and keeps a separate energy tally for every wire. On each accepted sample it compares the new bus word with the last accepted word. It classifies each wire as rising, falling or steady, and adds an integer cost to that wire's accumulator. The cost has two parts. The self part is charged whenever the wire itself moves. The coupling part covers the wire's neighbours one, two and three positions away, and each of those three distances has its own programmable weight.

Pair coupling follows the signed-change rule. Let d be +1 for a rise, −1 for a fall and 0 for steady. Wire i is then charged d_i² − d_i·d_j units for its partner j. This gives 0 units when wire i is steady or both wires move the same way, 1 unit when only wire i moves, and 2 units when the two wires move in opposite directions. The self weight is meant to cover line capacitance plus repeater loading, which is roughly 1.75 times the bare line. Choosing that weight and turning counts into physical energy is left to the user.

Software or a trace harness sets the four weights, streams bus samples with a valid strobe, and reads any wire's tally through an index-addressed read port. A clear input restarts all tallies.

Top module: `wire_energy_mon`

## Requirements
- R1: A wire whose bit changes between the previous accepted word and the new accepted word is charged the self weight once, for a rise and for a fall alike. A wire whose bit does not change is charged no self weight.
- R2: For a wire pair at a distance of 1, 2 or 3 where only one wire changes, the moving wire is charged 1 unit of that distance's weight and the steady wire is charged nothing.
- R3: For a wire pair at a distance of 1, 2 or 3 where the two wires change in opposite directions, each wire of the pair is charged 2 units of that distance's weight.
- R4: For a wire pair where both wires rise, or both fall, neither wire is charged any coupling cost for that pair.
- R5: Distances 1, 2 and 3 use the separate weights `wgt_d1`, `wgt_d2` and `wgt_d3`. Wire pairs four or more positions apart add nothing.
- R6: Wire 0 and wire NUM_WIRES−1 count only the neighbours that exist, on one side, at each distance.
- R7: When `smp_valid` is 0, neither the accumulators nor the stored previous word change. The next accepted word is compared against the last accepted word.
- R8: An accumulator that would pass its maximum value holds at all ones instead of wrapping, and it stays there until cleared.
- R9: When `clr` is 1 at a clock edge, every accumulator is zero after that edge. Clear takes precedence over accumulation, but a valid sample in the same cycle still updates the stored previous word.
- R10: After reset, every accumulator is zero and the stored previous word is all zeros. `rd_acc` shows, combinationally, the accumulator selected by `rd_idx`. An index of NUM_WIRES or above reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Accept `smp_bus` at this edge |
| smp_bus | input | NUM_WIRES | Sampled bus word |
| wgt_self | input | WGT_W | Self weight per moving wire |
| wgt_d1 | input | WGT_W | Coupling weight, distance 1 |
| wgt_d2 | input | WGT_W | Coupling weight, distance 2 |
| wgt_d3 | input | WGT_W | Coupling weight, distance 3 |
| clr | input | 1 | Synchronous clear of all accumulators |
| rd_idx | input | IDX_W | Wire to read |
| rd_acc | output | ACC_W | Accumulator of wire `rd_idx` |

## Verification
The bench builds the monitor with five wires, 4-bit weights and 10-bit accumulators. Five wires is the smallest bus in which the middle wire has neighbours at distances 1 and 2 on both sides, the edges reach distance 3, and one pair sits at distance 4 where it must be ignored. Every old/new pair of 5-bit words is swept under two weight sets, and each wire is compared with an arithmetic d_i² − d_i·d_j model. The narrow accumulator lets saturation be reached within a few dozen cycles at full weights.

// File: rtl/wem_pkg.sv
package wem_pkg;

   localparam int MAX_DIST = 3;

   typedef enum logic [1:0] {
      TR_STEADY = 2'b00,
      TR_RISE   = 2'b01,
      TR_FALL   = 2'b10
   } trans_e;

   // Coupling units charged to "me" for one partner: d_me^2 - d_me*d_other
   function automatic logic [1:0] pair_units(input trans_e me, input trans_e other);
      logic [1:0] u;
      if (me == TR_STEADY)          u = 2'd0;
      else if (other == TR_STEADY)  u = 2'd1;
      else if (other == me)         u = 2'd0;
      else                          u = 2'd2;
      return u;
   endfunction

endpackage

// File: rtl/wem_trans_classify.sv
module wem_trans_classify #(
   parameter int NUM_WIRES = 8
) (
   input  logic [NUM_WIRES-1:0] prev_i,
   input  logic [NUM_WIRES-1:0] cur_i,
   output wem_pkg::trans_e      tr_o [NUM_WIRES]
);
   for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
      always_comb begin
         case ({prev_i[w], cur_i[w]})
            2'b01:   tr_o[w] = wem_pkg::TR_RISE;
            2'b10:   tr_o[w] = wem_pkg::TR_FALL;
            default: tr_o[w] = wem_pkg::TR_STEADY;
         endcase
      end
   end
endmodule

// File: rtl/wem_wire_cost.sv
module wem_wire_cost #(
   parameter int NUM_WIRES = 8,
   parameter int IDX       = 0,
   parameter int WGT_W     = 8,
   localparam int COST_W   = WGT_W + 4
) (
   input  wem_pkg::trans_e    tr_i [NUM_WIRES],
   input  logic [WGT_W-1:0]   wgt_self_i,
   input  logic [WGT_W-1:0]   wgt_dist_i [wem_pkg::MAX_DIST],
   output logic [COST_W-1:0]  cost_o
);
   localparam int ND = wem_pkg::MAX_DIST;

   logic [1:0] lo_u [ND];
   logic [1:0] hi_u [ND];
   logic [COST_W-1:0] term [ND];

   for (genvar k = 1; k <= ND; k++) begin : g_dist
      if (IDX - k >= 0) begin : g_lo
         assign lo_u[k-1] = wem_pkg::pair_units(tr_i[IDX], tr_i[IDX-k]);
      end else begin : g_lo_none
         assign lo_u[k-1] = 2'd0;
      end
      if (IDX + k < NUM_WIRES) begin : g_hi
         assign hi_u[k-1] = wem_pkg::pair_units(tr_i[IDX], tr_i[IDX+k]);
      end else begin : g_hi_none
         assign hi_u[k-1] = 2'd0;
      end
      assign term[k-1] = COST_W'({1'b0, lo_u[k-1]} + {1'b0, hi_u[k-1]})
                         * COST_W'(wgt_dist_i[k-1]);
   end

   always_comb begin
      cost_o = (tr_i[IDX] != wem_pkg::TR_STEADY) ? COST_W'(wgt_self_i) : '0;
      for (int k = 0; k < ND; k++) cost_o = cost_o + term[k];
   end
endmodule

// File: rtl/wem_sat_accum.sv
module wem_sat_accum #(
   parameter int ACC_W  = 32,
   parameter int COST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [COST_W-1:0] cost_i,
   output logic [ACC_W-1:0]  acc_o
);
   logic [ACC_W:0] sum;

   assign sum = {1'b0, acc_o} + (ACC_W+1)'(cost_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             acc_o <= '0;
      else if (clr_i)         acc_o <= '0;
      else if (en_i) begin
         if (sum[ACC_W])      acc_o <= '1;
         else                 acc_o <= sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/wire_energy_mon.sv
module wire_energy_mon #(
   parameter int NUM_WIRES = 32,
   parameter int WGT_W     = 8,
   parameter int ACC_W     = 32,
   localparam int IDX_W    = $clog2(NUM_WIRES),
   localparam int COST_W   = WGT_W + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic [NUM_WIRES-1:0] smp_bus,
   input  logic [WGT_W-1:0]     wgt_self,
   input  logic [WGT_W-1:0]     wgt_d1,
   input  logic [WGT_W-1:0]     wgt_d2,
   input  logic [WGT_W-1:0]     wgt_d3,
   input  logic                 clr,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [ACC_W-1:0]     rd_acc
);
   if (NUM_WIRES < 2) begin : g_bad_wires
      $error("wire_energy_mon: NUM_WIRES must be at least 2");
   end
   if (ACC_W < COST_W) begin : g_bad_acc
      $error("wire_energy_mon: ACC_W must hold one cycle of cost");
   end

   logic [NUM_WIRES-1:0]       prev_q;
   wem_pkg::trans_e            tr [NUM_WIRES];
   logic [WGT_W-1:0]           wgt_dist [wem_pkg::MAX_DIST];
   logic [COST_W-1:0]          cost [NUM_WIRES];
   logic [ACC_W-1:0]           acc [NUM_WIRES];
   logic [NUM_WIRES*ACC_W-1:0] acc_flat;

   assign wgt_dist[0] = wgt_d1;
   assign wgt_dist[1] = wgt_d2;
   assign wgt_dist[2] = wgt_d3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev_q <= '0;
      else if (smp_valid) prev_q <= smp_bus;
   end

   wem_trans_classify #(.NUM_WIRES(NUM_WIRES)) u_class (
      .prev_i (prev_q),
      .cur_i  (smp_bus),
      .tr_o   (tr)
   );

   for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
      wem_wire_cost #(
         .NUM_WIRES (NUM_WIRES),
         .IDX       (w),
         .WGT_W     (WGT_W)
      ) u_cost (
         .tr_i       (tr),
         .wgt_self_i (wgt_self),
         .wgt_dist_i (wgt_dist),
         .cost_o     (cost[w])
      );

      wem_sat_accum #(.ACC_W(ACC_W), .COST_W(COST_W)) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (clr),
         .en_i   (smp_valid),
         .cost_i (cost[w]),
         .acc_o  (acc[w])
      );

      assign acc_flat[w*ACC_W +: ACC_W] = acc[w];
   end

   always_comb begin
      rd_acc = '0;
      for (int w = 0; w < NUM_WIRES; w++) begin
         if (rd_idx == IDX_W'(w)) rd_acc = acc[w];
      end
   end
endmodule

// File: rtl/wem_checker.sv
module wem_checker #(
   parameter int NUM_WIRES = 32,
   parameter int ACC_W     = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       smp_valid,
   input logic                       clr,
   input logic [NUM_WIRES-1:0]       smp_bus,
   input logic [NUM_WIRES-1:0]       prev_q,
   input logic [NUM_WIRES*ACC_W-1:0] acc_flat
);
   // R7: an idle cycle leaves every tally and the stored word alone
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !clr) |=> ($stable(acc_flat) && $stable(prev_q)));

   // R7: an accepted sample becomes the next comparison word
   p_prev_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (prev_q == $past(smp_bus)));

   // R9: clear empties every accumulator
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_flat == '0));

   // R1: a sample equal to the stored word moves no wire, so costs nothing
   p_no_move_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !clr && (smp_bus == prev_q)) |=> $stable(acc_flat));

   for (genvar w = 0; w < NUM_WIRES; w++) begin : g_w
      // R8: a tally never goes down without a clear
      p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (acc_flat[w*ACC_W +: ACC_W] >= $past(acc_flat[w*ACC_W +: ACC_W])));
      // R8: a saturated tally stays saturated
      p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && (&acc_flat[w*ACC_W +: ACC_W])) |=> (&acc_flat[w*ACC_W +: ACC_W]));
   end
endmodule

bind wire_energy_mon wem_checker #(.NUM_WIRES(NUM_WIRES), .ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .clr       (clr),
   .smp_bus   (smp_bus),
   .prev_q    (prev_q),
   .acc_flat  (acc_flat)
);

// File: tb/wire_energy_mon_tb_top.sv
`timescale 1ns/1ps
module wire_energy_mon_tb_top;
   localparam int NW = 5;
   localparam int WW = 4;
   localparam int AW = 10;
   localparam int IW = $clog2(NW);
   localparam int AMAX = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [NW-1:0] smp_bus = '0;
   logic [WW-1:0] wgt_self = '0, wgt_d1 = '0, wgt_d2 = '0, wgt_d3 = '0;
   logic          clr = 1'b0;
   logic [IW-1:0] rd_idx = '0;
   logic [AW-1:0] rd_acc;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   int acc_m [NW];
   logic [NW-1:0] prev_m = '0;

   always #2.5 clk = ~clk;

   wire_energy_mon #(.NUM_WIRES(NW), .WGT_W(WW), .ACC_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
      .wgt_self(wgt_self), .wgt_d1(wgt_d1), .wgt_d2(wgt_d2), .wgt_d3(wgt_d3),
      .clr(clr), .rd_idx(rd_idx), .rd_acc(rd_acc)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int wcost(input int i, input logic [NW-1:0] o, input logic [NW-1:0] n);
      int d [NW];
      int w [4];
      int c;
      w[0] = wgt_self; w[1] = wgt_d1; w[2] = wgt_d2; w[3] = wgt_d3;
      for (int k = 0; k < NW; k++) d[k] = int'(n[k]) - int'(o[k]);
      c = w[0] * d[i] * d[i];
      for (int k = 1; k <= 3; k++) begin
         if (i - k >= 0) c += w[k] * (d[i]*d[i] - d[i]*d[i-k]);
         if (i + k < NW) c += w[k] * (d[i]*d[i] - d[i]*d[i+k]);
      end
      return c;
   endfunction

   task automatic read_wire(input int i, output int v);
      rd_idx = IW'(i);
      #0.2;
      v = int'(rd_acc);
   endtask

   task automatic compare_all(input string tag);
      int v;
      for (int i = 0; i < NW; i++) begin
         read_wire(i, v);
         chk($sformatf("%s wire %0d", tag, i), v, acc_m[i]);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare after
   task automatic step(input logic v, input logic [NW-1:0] b, input logic c, input string tag);
      @(negedge clk);
      smp_valid = v; smp_bus = b; clr = c;
      @(posedge clk);
      if (c) begin
         for (int i = 0; i < NW; i++) acc_m[i] = 0;
      end else if (v) begin
         for (int i = 0; i < NW; i++) begin
            acc_m[i] += wcost(i, prev_m, b);
            if (acc_m[i] > AMAX) acc_m[i] = AMAX;
         end
      end
      if (v) prev_m = b;
      #0.5;
      smp_valid = 1'b0; clr = 1'b0;
      compare_all(tag);
   endtask

   task automatic set_w(input int s, input int a, input int b, input int c);
      @(negedge clk);
      wgt_self = WW'(s); wgt_d1 = WW'(a); wgt_d2 = WW'(b); wgt_d3 = WW'(c);
   endtask

   // load old word, clear, apply new word
   task automatic one_trans(input logic [NW-1:0] o, input logic [NW-1:0] n, input string tag);
      step(1'b1, o, 1'b0, tag);
      step(1'b0, o, 1'b1, tag);
      step(1'b1, n, 1'b0, tag);
   endtask

   initial begin
      int v;
      for (int i = 0; i < NW; i++) acc_m[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      compare_all("R10 reset");
      rd_idx = IW'(NW); #0.2;
      chk("R10 out-of-range index", int'(rd_acc), 0);

      // R1 self weight only
      set_w(3, 0, 0, 0);
      one_trans(5'b00000, 5'b00100, "R1 rise");
      read_wire(2, v); chk("R1 rise self", v, 3);
      read_wire(1, v); chk("R1 steady wire no self", v, 0);
      one_trans(5'b00100, 5'b00000, "R1 fall");
      read_wire(2, v); chk("R1 fall self", v, 3);

      // R2 single mover with steady neighbours at distance 1
      set_w(0, 1, 0, 0);
      one_trans(5'b00000, 5'b00100, "R2");
      read_wire(2, v); chk("R2 mover charged", v, 2);
      read_wire(1, v); chk("R2 steady neighbour free", v, 0);
      read_wire(3, v); chk("R2 steady neighbour free", v, 0);

      // R3 opposite moves on wires 1 and 2
      one_trans(5'b00010, 5'b00100, "R3");
      read_wire(1, v); chk("R3 toggle wire1", v, 3);
      read_wire(2, v); chk("R3 toggle wire2", v, 3);

      // R4 all wires rise together
      set_w(0, 1, 1, 1);
      one_trans(5'b00000, 5'b11111, "R4");
      for (int i = 0; i < NW; i++) begin
         read_wire(i, v); chk("R4 same direction free", v, 0);
      end

      // R5 distance-3 weight alone; distance-4 pair ignored
      set_w(0, 0, 0, 1);
      one_trans(5'b00000, 5'b00001, "R5 d3");
      read_wire(0, v); chk("R5 distance3 weight", v, 1);
      set_w(1, 2, 3, 4);
      one_trans(5'b00001, 5'b10000, "R5 d4");
      read_wire(0, v); chk("R5 distance4 ignored wire0", v, 10);
      read_wire(4, v); chk("R5 distance4 ignored wire4", v, 10);

      // R3 pattern up-up-down-up-up, middle wire
      one_trans(5'b00100, 5'b11011, "R3 uudud");
      read_wire(2, v); chk("R3 middle wire thermal case", v, 21);
      // R6 pattern down-up-down-up-down, edge wire
      one_trans(5'b10101, 5'b01010, "R6 dudud");
      read_wire(0, v); chk("R6 edge wire", v, 13);

      // exhaustive sweeps: R1 R2 R3 R4 R5 R6 against model
      set_w(1, 2, 3, 4);
      for (int o = 0; o < 32; o++)
         for (int n = 0; n < 32; n++)
            one_trans(NW'(o), NW'(n), "sweep A (R1 R2 R3 R4 R5 R6)");
      set_w(5, 11, 0, 7);
      for (int o = 0; o < 32; o++)
         for (int n = 0; n < 32; n++)
            one_trans(NW'(o), NW'(n), "sweep B (R1 R2 R3 R4 R5 R6)");

      // R8 saturation
      set_w(15, 15, 15, 15);
      step(1'b0, 5'b00000, 1'b1, "R8 clear");
      for (int c = 0; c < 24; c++)
         step(1'b1, (c % 2) ? 5'b10101 : 5'b01010, 1'b0, "R8 accumulate");
      for (int i = 0; i < NW; i++) begin
         read_wire(i, v); chk("R8 saturated", v, AMAX);
      end

      // R7 idle cycles ignore the bus
      step(1'b0, 5'b11111, 1'b0, "R7 idle");
      step(1'b1, 5'b00000, 1'b1, "R9 clear with valid");
      for (int i = 0; i < NW; i++) begin
         read_wire(i, v); chk("R9 cleared", v, 0);
      end
      step(1'b0, 5'b11011, 1'b0, "R7 idle diff");
      step(1'b0, 5'b00110, 1'b0, "R7 idle diff");
      step(1'b1, 5'b00000, 1'b0, "R7 same as last accepted");
      for (int i = 0; i < NW; i++) begin
         read_wire(i, v); chk("R7 idle word not stored", v, 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule